// File: doc/BRIEF.md
# Buck Converter Gate Sequencer

This block drives the two power switches of one step-down converter channel from comparator results that have already been digitized into the system clock domain. It has two operating styles. Fixed-frequency peak-current operation turns the high-side switch on at every cycle start and off when the slope comparator or the current limit trips. Light-load pulse operation fires a fixed minimum on-time whenever the output-low comparator trips, with the low-side device held as a current source while the high-side switch conducts.

A dead gap of `DEAD_CLKS` clocks always separates high-side turn-off from low-side turn-on. When no comparator trips, the high-side switch stays on across cycle boundaries, which gives full duty. Automatic operation moves to the pulse style after a run of lightly loaded cycles and returns when the load grows. A forced mode keeps the channel in fixed-frequency operation. A low enable or an active fault parks both switches off at once.

Top module: `buck_sw_ctrl`

## Requirements
- R1: When `enable` is low or `fault` is high at a clock edge, all three outputs are low after that edge and the sequencer is idle. From idle, no switch turns on before the next `cycle_start`, and that first start always begins a fixed-frequency cycle.
- R2: In fixed-frequency operation, a `cycle_start` seen while idle or during the low-side phase turns `hs_gate` on after the next clock edge.
- R3: While `hs_gate` is on in fixed-frequency operation, a `pwm_trip` or `ilim_trip` turns it off after the next edge. A trip that arrives together with `cycle_start` wins.
- R4: After any high-side turn-off, both gates stay low for exactly `DEAD_CLKS` clocks (default 2) before `ls_gate` rises. `hs_gate` and `ls_gate` are never high together.
- R5: If no trip occurs, `hs_gate` stays on through any number of `cycle_start` pulses (full duty).
- R6: A `zero_cross` seen while `ls_gate` is on turns `ls_gate` off and `ls_src` on after the next edge. In fixed-frequency operation the current-source state holds until the next `cycle_start`.
- R7: In automatic operation, count the fixed-frequency cycles that end in the current-source state. When 8 such cycles in a row have ended (default `LIGHT_CYCLES`), the `cycle_start` that closes the eighth one enters the pulse wait state instead of turning `hs_gate` on. In that state only `ls_src` is high and `cycle_start` is ignored. A cycle that ends with `ls_gate` or `hs_gate` still on clears the count.
- R8: In the pulse wait state, `out_low` turns `hs_gate` and `ls_src` on together after the next edge, for exactly `MIN_ON_CLKS` clocks (default 6). Then follow the dead gap and `ls_gate`. An `ilim_trip` during the on-time ends it after the next edge.
- R9: In pulse operation, `zero_cross` during the low-side phase returns to the wait state (`ls_src` only). The next `out_low` turns `hs_gate` on after the following edge.
- R10: When 2 pulse on-times in a row (default `HEAVY_MISSES`) end with no `pwm_trip` seen during them, the second one is followed by the dead gap and a fixed-frequency low-side phase, so the next `cycle_start` turns `hs_gate` on. An on-time with a trip clears this count.
- R11: While `force_pwm` is high, the pulse on-state is never entered. With `force_pwm` high in the pulse wait state, the sequencer moves to the fixed-frequency current-source state after the next edge: `out_low` then has no effect and `cycle_start` turns `hs_gate` on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable, active high |
| fault | input | 1 | Protection fault, forces both switches off |
| cycle_start | input | 1 | One-clock pulse from the switching oscillator |
| pwm_trip | input | 1 | Peak-current slope comparator result |
| ilim_trip | input | 1 | Cycle current-limit comparator result |
| out_low | input | 1 | Output-below-threshold comparator for pulse operation |
| zero_cross | input | 1 | Inductor current reached zero |
| force_pwm | input | 1 | Keep fixed-frequency operation |
| hs_gate | output | 1 | High-side switch on |
| ls_gate | output | 1 | Low-side switch fully on |
| ls_src | output | 1 | Low-side switch in current-source state |

## Verification
The bench targets these corner cases:
- A trip that coincides with a cycle start. A design that ranked them wrongly would stretch the on-time by a whole cycle.
- A trip-free run across several starts. A design that restarted the cycle would chop full duty.
- The exact length of the dead gap and of the pulse on-time. An off-by-one in the shared timer would shift each of them by a clock.
- The cycle on which the light-load count reaches its limit, and a run broken by a non-zero-crossing cycle. A design that counted wrongly would enter or leave pulse operation one cycle early or late.
- Forced mode asserted while in the pulse wait state. A design that ignored it there would still fire an on-time on `out_low`.
- The two-miss exit, the current-limit cut of a pulse, and fault or enable removal in the middle of a conduction phase.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_HS_RUN  = 4'd1,
      ST_GAP_A   = 4'd2,
      ST_LS_RUN  = 4'd3,
      ST_LS_SRC  = 4'd4,
      ST_LT_WAIT = 4'd5,
      ST_LT_ON   = 4'd6,
      ST_GAP_B   = 4'd7,
      ST_LT_LS   = 4'd8
   } bsc_state_e;

   typedef struct packed {
      logic hs;
      logic ls;
      logic src;
   } bsc_gate_t;

   function automatic bsc_gate_t gate_of(bsc_state_e s);
      bsc_gate_t g;
      g = '0;
      case (s)
         ST_HS_RUN:  g.hs  = 1'b1;
         ST_LS_RUN:  g.ls  = 1'b1;
         ST_LS_SRC:  g.src = 1'b1;
         ST_LT_WAIT: g.src = 1'b1;
         ST_LT_ON: begin
            g.hs  = 1'b1;
            g.src = 1'b1;
         end
         ST_LT_LS:   g.ls  = 1'b1;
         default:    g = '0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/bsc_dly_timer.sv
module bsc_dly_timer #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/bsc_load_track.sv
module bsc_load_track #(
   parameter int LIGHT_CYCLES = 8,
   parameter int HEAVY_MISSES = 2,
   parameter bit AUTO_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic force_pwm,
   input  logic end_zc,
   input  logic end_nozc,
   input  logic on_start,
   input  logic on_active,
   input  logic on_end,
   input  logic pwm_trip,
   output logic light_hit,
   output logic heavy_hit
);
   localparam int ZW = $clog2(LIGHT_CYCLES + 1);
   localparam int MW = $clog2(HEAVY_MISSES + 1);

   generate
      if (AUTO_EN) begin : g_auto
         localparam logic [ZW-1:0] ZC_LAST   = ZW'(LIGHT_CYCLES - 1);
         localparam logic [MW-1:0] MISS_LAST = MW'(HEAVY_MISSES - 1);

         logic [ZW-1:0] zc_q;
         logic [MW-1:0] miss_q;
         logic          trip_q;
         logic          tripped;

         assign tripped   = trip_q | pwm_trip;
         assign light_hit = !force_pwm && (zc_q == ZC_LAST);
         assign heavy_hit = (miss_q == MISS_LAST) && !tripped;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           zc_q <= '0;
            else if (clr || force_pwm || end_nozc) zc_q <= '0;
            else if (end_zc)                      zc_q <= light_hit ? '0 : zc_q + 1'b1;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   miss_q <= '0;
            else if (clr || force_pwm || (end_zc && light_hit)) miss_q <= '0;
            else if (on_end) begin
               if (tripped || (miss_q == MISS_LAST))      miss_q <= '0;
               else                                       miss_q <= miss_q + 1'b1;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    trip_q <= 1'b0;
            else if (clr || on_start)      trip_q <= 1'b0;
            else if (on_active && pwm_trip) trip_q <= 1'b1;
         end
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ clr ^ force_pwm ^ end_zc ^ end_nozc
                          ^ on_start ^ on_active ^ on_end ^ pwm_trip;
         assign light_hit = 1'b0;
         assign heavy_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bsc_gate_map.sv
module bsc_gate_map
   import bsc_pkg::*;
(
   input  bsc_state_e st,
   output logic       hs,
   output logic       ls,
   output logic       src
);
   bsc_gate_t g;
   assign g   = gate_of(st);
   assign hs  = g.hs;
   assign ls  = g.ls;
   assign src = g.src;
endmodule

// File: rtl/buck_sw_ctrl.sv
module buck_sw_ctrl
   import bsc_pkg::*;
#(
   parameter int DEAD_CLKS    = 2,
   parameter int MIN_ON_CLKS  = 6,
   parameter int LIGHT_CYCLES = 8,
   parameter int HEAVY_MISSES = 2,
   parameter bit AUTO_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fault,
   input  logic cycle_start,
   input  logic pwm_trip,
   input  logic ilim_trip,
   input  logic out_low,
   input  logic zero_cross,
   input  logic force_pwm,
   output logic hs_gate,
   output logic ls_gate,
   output logic ls_src
);
   localparam int TMAX = (DEAD_CLKS > MIN_ON_CLKS) ? DEAD_CLKS : MIN_ON_CLKS;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] GAP_LD = TW'(DEAD_CLKS - 1);
   localparam logic [TW-1:0] ON_LD  = TW'(MIN_ON_CLKS - 1);

   generate
      if (DEAD_CLKS < 1) begin : g_bad_dead
         $error("DEAD_CLKS must be at least 1");
      end
      if (MIN_ON_CLKS < 1) begin : g_bad_on
         $error("MIN_ON_CLKS must be at least 1");
      end
      if (LIGHT_CYCLES < 1) begin : g_bad_light
         $error("LIGHT_CYCLES must be at least 1");
      end
      if (HEAVY_MISSES < 1) begin : g_bad_heavy
         $error("HEAVY_MISSES must be at least 1");
      end
   endgenerate

   bsc_state_e st_q, st_d;
   logic       clr;
   logic       t_load, t_zero;
   logic [TW-1:0] t_val;
   logic       end_zc, end_nozc, on_start, on_end;
   logic       light_hit, heavy_hit;

   assign clr = !enable || fault;

   always_comb begin
      st_d     = st_q;
      t_load   = 1'b0;
      t_val    = GAP_LD;
      end_zc   = 1'b0;
      end_nozc = 1'b0;
      on_start = 1'b0;
      on_end   = 1'b0;
      if (clr) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cycle_start) st_d = ST_HS_RUN;
            end
            ST_HS_RUN: begin
               if (pwm_trip || ilim_trip) begin
                  st_d   = ST_GAP_A;
                  t_load = 1'b1;
               end else if (cycle_start) begin
                  end_nozc = 1'b1;
               end
            end
            ST_GAP_A: begin
               if (t_zero) st_d = ST_LS_RUN;
            end
            ST_LS_RUN: begin
               if (cycle_start) begin
                  st_d     = ST_HS_RUN;
                  end_nozc = 1'b1;
               end else if (zero_cross) begin
                  st_d = ST_LS_SRC;
               end
            end
            ST_LS_SRC: begin
               if (cycle_start) begin
                  end_zc = 1'b1;
                  st_d   = light_hit ? ST_LT_WAIT : ST_HS_RUN;
               end
            end
            ST_LT_WAIT: begin
               if (force_pwm) begin
                  st_d = ST_LS_SRC;
               end else if (out_low) begin
                  st_d     = ST_LT_ON;
                  t_load   = 1'b1;
                  t_val    = ON_LD;
                  on_start = 1'b1;
               end
            end
            ST_LT_ON: begin
               if (ilim_trip) begin
                  st_d   = ST_GAP_B;
                  t_load = 1'b1;
               end else if (t_zero) begin
                  on_end = 1'b1;
                  t_load = 1'b1;
                  st_d   = heavy_hit ? ST_GAP_A : ST_GAP_B;
               end
            end
            ST_GAP_B: begin
               if (t_zero) st_d = ST_LT_LS;
            end
            ST_LT_LS: begin
               if (zero_cross) st_d = force_pwm ? ST_LS_SRC : ST_LT_WAIT;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   bsc_dly_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   bsc_load_track #(
      .LIGHT_CYCLES (LIGHT_CYCLES),
      .HEAVY_MISSES (HEAVY_MISSES),
      .AUTO_EN      (AUTO_EN)
   ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .force_pwm (force_pwm),
      .end_zc    (end_zc),
      .end_nozc  (end_nozc),
      .on_start  (on_start),
      .on_active (st_q == ST_LT_ON),
      .on_end    (on_end),
      .pwm_trip  (pwm_trip),
      .light_hit (light_hit),
      .heavy_hit (heavy_hit)
   );

   bsc_gate_map u_map (
      .st  (st_q),
      .hs  (hs_gate),
      .ls  (ls_gate),
      .src (ls_src)
   );
endmodule

// File: rtl/buck_sw_ctrl_sva.sv
module buck_sw_ctrl_sva (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic fault,
   input logic cycle_start,
   input logic pwm_trip,
   input logic ilim_trip,
   input logic zero_cross,
   input logic force_pwm,
   input logic hs_gate,
   input logic ls_gate,
   input logic ls_src
);
   // R1
   a_r1_park_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable || fault) |=> (!hs_gate && !ls_gate && !ls_src));

   // R3
   a_r3_trip_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fault && hs_gate && (ilim_trip || (pwm_trip && !ls_src))) |=> !hs_gate);

   // R4
   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   // R4
   a_r4_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> !$past(hs_gate));

   // R5
   a_r5_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fault && hs_gate && !ls_src && !pwm_trip && !ilim_trip) |=> hs_gate);

   // R6
   a_r6_zc_to_src: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !fault && ls_gate && zero_cross && !cycle_start) |=> (ls_src && !ls_gate));

   // R11
   a_r11_no_pulse_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (force_pwm && !(hs_gate && ls_src)) |=> !(hs_gate && ls_src));
endmodule

bind buck_sw_ctrl buck_sw_ctrl_sva u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .fault       (fault),
   .cycle_start (cycle_start),
   .pwm_trip    (pwm_trip),
   .ilim_trip   (ilim_trip),
   .zero_cross  (zero_cross),
   .force_pwm   (force_pwm),
   .hs_gate     (hs_gate),
   .ls_gate     (ls_gate),
   .ls_src      (ls_src)
);

// File: tb/buck_sw_ctrl_test.sv
module buck_sw_ctrl_test;
   localparam int DT    = 2;
   localparam int MON   = 6;
   localparam int LIGHT = 8;
   localparam int HEAVY = 2;

   localparam int M_OFF = 0, M_HS = 1, M_GA = 2, M_LS = 3, M_CS = 4,
                  M_WT = 5, M_PON = 6, M_GB = 7, M_PLS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, flt = 1'b0, cs = 1'b0, pt = 1'b0, il = 1'b0;
   logic pl = 1'b0, zd = 1'b0, fp = 1'b0;
   logic hs, ls, src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int m_st = M_OFF, m_tmr = 0, m_zc = 0, m_miss = 0;
   bit m_trip = 1'b0;

   always #5 clk = ~clk;

   buck_sw_ctrl uut (
      .clk (clk), .rst_n (rst_n), .enable (en), .fault (flt),
      .cycle_start (cs), .pwm_trip (pt), .ilim_trip (il), .out_low (pl),
      .zero_cross (zd), .force_pwm (fp),
      .hs_gate (hs), .ls_gate (ls), .ls_src (src)
   );

   function automatic logic [2:0] exp_out(int s);
      case (s)
         M_HS:  return 3'b100;
         M_LS:  return 3'b010;
         M_CS:  return 3'b001;
         M_WT:  return 3'b001;
         M_PON: return 3'b101;
         M_PLS: return 3'b010;
         default: return 3'b000;
      endcase
   endfunction

   function automatic string tag_of(int s);
      case (s)
         M_OFF: return "R1";
         M_HS:  return "R2";
         M_GA:  return "R4";
         M_LS:  return "R4";
         M_CS:  return "R6";
         M_WT:  return "R7";
         M_PON: return "R8";
         M_GB:  return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic model_step();
      bit tr;
      if (!en || flt) begin
         m_st = M_OFF; m_zc = 0; m_miss = 0; m_trip = 1'b0;
         return;
      end
      case (m_st)
         M_OFF: if (cs) m_st = M_HS;
         M_HS: begin
            if (pt || il) begin m_st = M_GA; m_tmr = DT; end
            else if (cs) m_zc = 0;
         end
         M_GA: begin m_tmr--; if (m_tmr == 0) m_st = M_LS; end
         M_LS: begin
            if (cs) begin m_zc = 0; m_st = M_HS; end
            else if (zd) m_st = M_CS;
         end
         M_CS: if (cs) begin
            if (!fp && m_zc == LIGHT - 1) begin m_zc = 0; m_miss = 0; m_st = M_WT; end
            else begin m_zc++; m_st = M_HS; end
         end
         M_WT: begin
            if (fp) m_st = M_CS;
            else if (pl) begin m_st = M_PON; m_tmr = MON; m_trip = 1'b0; end
         end
         M_PON: begin
            if (pt) m_trip = 1'b1;
            if (il) begin m_st = M_GB; m_tmr = DT; end
            else begin
               m_tmr--;
               if (m_tmr == 0) begin
                  tr = m_trip;
                  m_tmr = DT;
                  if (tr) begin m_miss = 0; m_st = M_GB; end
                  else if (m_miss == HEAVY - 1) begin m_miss = 0; m_st = M_GA; end
                  else begin m_miss++; m_st = M_GB; end
               end
            end
         end
         M_GB: begin m_tmr--; if (m_tmr == 0) m_st = M_PLS; end
         M_PLS: if (zd) m_st = fp ? M_CS : M_WT;
         default: m_st = M_OFF;
      endcase
      if (fp) begin m_zc = 0; m_miss = 0; end
   endtask

   task automatic chk(string tag, logic [2:0] want);
      checks++;
      if ({hs, ls, src} !== want) begin
         errors++;
         $display("FAIL %s: gates hs/ls/src actual %b expected %b at %0t", tag, {hs, ls, src}, want, $time);
      end
   endtask

   task automatic step(string tag);
      model_step();
      @(posedge clk);
      #1;
      chk(tag, exp_out(m_st));
      checks++;
      if (hs && ls) begin
         errors++;
         $display("FAIL R4: overlap actual hs=%b ls=%b expected not both", hs, ls);
      end
   endtask

   task automatic pulse_cs(string tag);
      cs = 1'b1; step(tag); cs = 1'b0;
   endtask

   task automatic pwm_zc_cycle(string tag);
      pulse_cs(tag);
      step(tag);
      pt = 1'b1; step(tag); pt = 1'b0;
      step(tag);
      step(tag);
      zd = 1'b1; step(tag); zd = 1'b0;
   endtask

   task automatic pulse_on(string tag, bit with_trip);
      pl = 1'b1; step(tag); pl = 1'b0;
      for (int i = 0; i < MON - 1; i++) begin
         pt = with_trip && (i == 0);
         step(tag);
         chk(tag, 3'b101);
      end
      pt = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1", 3'b000);
      en = 1'b1;
      step("R1"); step("R1");
      chk("R1", 3'b000);

      pulse_cs("R2"); chk("R2", 3'b100);
      step("R5"); step("R5");
      pulse_cs("R5"); chk("R5", 3'b100);
      pulse_cs("R5"); chk("R5", 3'b100);
      pt = 1'b1; step("R3"); pt = 1'b0; chk("R3", 3'b000);
      step("R4"); chk("R4", 3'b000);
      step("R4"); chk("R4", 3'b010);
      zd = 1'b1; step("R6"); zd = 1'b0; chk("R6", 3'b001);
      step("R6"); chk("R6", 3'b001);

      for (int i = 0; i < LIGHT - 1; i++) pwm_zc_cycle("R7");
      pulse_cs("R7"); chk("R7", 3'b001);
      pulse_cs("R7"); chk("R7", 3'b001);

      pulse_on("R8", 1'b1);
      step("R8"); chk("R8", 3'b000);
      step("R8"); chk("R8", 3'b000);
      step("R8"); chk("R8", 3'b010);
      zd = 1'b1; step("R9"); zd = 1'b0; chk("R9", 3'b001);
      pl = 1'b1; step("R9"); pl = 1'b0; chk("R9", 3'b101);
      il = 1'b1; step("R8"); il = 1'b0; chk("R8", 3'b000);
      step("R8"); step("R8"); chk("R8", 3'b010);
      zd = 1'b1; step("R9"); zd = 1'b0;

      pulse_on("R10", 1'b0);
      step("R10"); step("R10"); step("R10"); chk("R10", 3'b010);
      zd = 1'b1; step("R10"); zd = 1'b0; chk("R10", 3'b001);
      pulse_on("R10", 1'b0);
      step("R10"); step("R10"); step("R10"); chk("R10", 3'b010);
      pulse_cs("R10"); chk("R10", 3'b100);

      cs = 1'b1; pt = 1'b1; step("R3"); cs = 1'b0; pt = 1'b0; chk("R3", 3'b000);
      step("R4"); step("R4"); chk("R4", 3'b010);

      fp = 1'b1;
      for (int i = 0; i < LIGHT + 1; i++) pwm_zc_cycle("R11");
      pulse_cs("R11"); chk("R11", 3'b100);
      pt = 1'b1; step("R11"); pt = 1'b0;
      step("R11"); step("R11");
      zd = 1'b1; step("R11"); zd = 1'b0;
      fp = 1'b0;
      for (int i = 0; i < LIGHT - 1; i++) pwm_zc_cycle("R7");
      pulse_cs("R7"); chk("R7", 3'b001);
      fp = 1'b1; step("R11");
      pl = 1'b1; step("R11"); pl = 1'b0; chk("R11", 3'b001);
      pulse_cs("R11"); chk("R11", 3'b100);
      fp = 1'b0;

      flt = 1'b1; step("R1"); flt = 1'b0; chk("R1", 3'b000);
      step("R1"); chk("R1", 3'b000);
      pulse_cs("R2"); chk("R2", 3'b100);
      en = 1'b0; step("R1"); en = 1'b1; chk("R1", 3'b000);

      for (int i = 0; i < 6000; i++) begin
         cs  = ($urandom % 12) == 0;
         pt  = ($urandom % 5) == 0;
         il  = ($urandom % 50) == 0;
         pl  = ($urandom % 4) == 0;
         zd  = ($urandom % 3) == 0;
         if (($urandom % 400) == 0) fp = !fp;
         en  = ($urandom % 600) != 0;
         flt = ($urandom % 900) == 0;
         step(tag_of(m_st));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual still running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule